// File: doc/BRIEF.md
# FPGA Configuration Sequencer

This block is a controller that loads an FPGA through its byte-wide slave-parallel port. A one-cycle start pulse makes it clear the target's configuration memory by pulling the active-low program line. It then follows a two-step handshake on the target's active-low init line. Program is released once init is seen low. Nothing is loaded until init has returned high.

After the handshake, chip select and write are both driven low and stay low for the whole load. Configuration bytes arrive on a valid/ready stream and are taken one at a time. Each accepted byte is placed on the data bus and clocked into the target by a single high pulse of the configuration clock. The load stops when the target raises done or when an end pulse arrives. At that point chip select and write are released and a finished flag is raised. A new start pulse at any time restarts the whole sequence from the clear step.

All pin outputs come from registers, so each one changes one system-clock cycle after the internal state that drives it.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset, programN, chipSelN and writeN are 1, cfgClk is 0, and busy, finished and inReady are 0.
- R2: Two cycles after a start pulse is presented, programN is 0 and busy is 1. programN stays 0 while initN stays high, and programN is never 0 while chipSelN is 0.
- R3: When initN is seen low during the clear step, programN returns to 1 two cycles later. While initN then stays low, chipSelN and writeN stay 1 and inReady stays 0.
- R4: When initN returns high, inReady rises one cycle later, and chipSelN and writeN go to 0 two cycles later.
- R5: For each accepted byte, cfgClk is high for exactly one cycle. cfgData holds the byte for the cycle before the rising edge of cfgClk and for the cycle after its falling edge.
- R6: A byte is accepted on a clock edge where inValid and inReady are both 1. inReady is 0 in the cycle after an acceptance. Every accepted byte yields exactly one cfgClk pulse, in acceptance order.
- R7: chipSelN and writeN stay 0 throughout the load, including between bytes and during every cfgClk pulse.
- R8: doneIn high during the load causes chipSelN, writeN and finished to become 1 two cycles later, busy to become 0, and inReady to drop.
- R9: An endPulse during the load has the same effect as doneIn (R8).
- R10: A start pulse during the load restarts the sequence. Two cycles later programN is 0, chipSelN is 1, busy is 1 and inReady is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to begin (or restart) configuration |
| endPulse | input | 1 | One-cycle request to end the load |
| inData | input | DATA_W | Configuration byte from the stream |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Sequencer will take the stream byte on this edge |
| initN | input | 1 | Target init line, active low |
| doneIn | input | 1 | Target done line |
| programN | output | 1 | Target program line, active low |
| chipSelN | output | 1 | Target chip select, active low |
| writeN | output | 1 | Target write strobe, active low |
| cfgClk | output | 1 | Configuration clock to the target |
| cfgData | output | DATA_W | Configuration data bus |
| busy | output | 1 | Sequence in progress |
| finished | output | 1 | Load completed |

## Verification
The load path is swept with all 256 byte values, sent back to back with inValid held high. This shows that every value travels unchanged and that ready throttling by itself keeps one pulse per byte. A second pass sends a computed byte sequence with idle gaps of zero to three cycles. It catches lost, doubled or reordered bytes when the stream stalls. The handshake is driven with init held in each state for several cycles, which separates a sequencer that waits on init from one that runs on a fixed delay. The load is ended once by done and once by the end pulse, and a restart is requested in the middle of a load, so that each exit path is seen on its own.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_WAIT_INIT,
    ST_TAKE,
    ST_PULSE,
    ST_HOLD,
    ST_FINISHED
  } seqState_t;

  // Strobes from control to datapath; the datapath registers them onto pins.
  typedef struct packed {
    logic progLow;
    logic loadSel;
    logic clkHigh;
    logic capture;
    logic busy;
    logic finished;
  } pinStrobe_t;

endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       endPulse,
  input  logic       inValid,
  input  logic       initN,
  input  logic       doneIn,
  output logic       inReady,
  output pinStrobe_t strobe
);

  seqState_t state;
  seqState_t nextState;
  logic      loading;
  logic      stopLoad;

  assign loading  = (state == ST_TAKE) || (state == ST_PULSE) || (state == ST_HOLD);
  assign stopLoad = loading && (doneIn || endPulse);
  // Ready is withdrawn in any cycle where the byte could not be consumed.
  assign inReady  = (state == ST_TAKE) && !startPulse && !doneIn && !endPulse;

  always_comb begin
    nextState = state;
    if (startPulse) begin
      nextState = ST_CLEAR;
    end else if (stopLoad) begin
      nextState = ST_FINISHED;
    end else begin
      case (state)
        ST_CLEAR:     if (!initN) nextState = ST_WAIT_INIT;
        ST_WAIT_INIT: if (initN) nextState = ST_TAKE;
        ST_TAKE:      if (inValid) nextState = ST_PULSE;
        ST_PULSE:     nextState = ST_HOLD;
        ST_HOLD:      nextState = ST_TAKE;
        default:      nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.progLow  = (state == ST_CLEAR);
    strobe.loadSel  = loading;
    strobe.clkHigh  = (state == ST_PULSE);
    strobe.capture  = inReady && inValid;
    strobe.busy     = (state != ST_IDLE) && (state != ST_FINISHED);
    strobe.finished = (state == ST_FINISHED);
  end

  AST_ONE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |=> !inReady); // R6

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (loading && doneIn && !startPulse) |=> strobe.finished); // R8

  AST_END_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (loading && endPulse && !startPulse) |=> strobe.finished); // R9

  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (strobe.progLow && !strobe.loadSel)); // R10

endmodule

// File: rtl/cfg_seq_dpath.sv
module cfg_seq_dpath
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  output logic              programN,
  output logic              chipSelN,
  output logic              writeN,
  output logic              cfgClk,
  output logic [DATA_W-1:0] cfgData,
  output logic              busy,
  output logic              finished
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      programN <= 1'b1;
      chipSelN <= 1'b1;
      writeN   <= 1'b1;
      cfgClk   <= 1'b0;
      busy     <= 1'b0;
      finished <= 1'b0;
    end else begin
      programN <= !strobe.progLow;
      chipSelN <= !strobe.loadSel;
      writeN   <= !strobe.loadSel;
      cfgClk   <= strobe.clkHigh;
      busy     <= strobe.busy;
      finished <= strobe.finished;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cfgData <= '0;
    else if (strobe.capture) cfgData <= inData;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |=> !cfgClk); // R5

  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgClk) |-> $stable(cfgData)); // R5

  AST_SELECT_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> (!chipSelN && !writeN)); // R7

  AST_PROG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !programN |-> chipSelN); // R2

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              endPulse,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              initN,
  input  logic              doneIn,
  output logic              programN,
  output logic              chipSelN,
  output logic              writeN,
  output logic              cfgClk,
  output logic [DATA_W-1:0] cfgData,
  output logic              busy,
  output logic              finished
);

  cfg_seq_pkg::pinStrobe_t strobe;

  cfg_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .endPulse   (endPulse),
    .inValid    (inValid),
    .initN      (initN),
    .doneIn     (doneIn),
    .inReady    (inReady),
    .strobe     (strobe)
  );

  cfg_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .programN (programN),
    .chipSelN (chipSelN),
    .writeN   (writeN),
    .cfgClk   (cfgClk),
    .cfgData  (cfgData),
    .busy     (busy),
    .finished (finished)
  );

endmodule

// File: tb/cfg_seq_top_test.sv
module cfg_seq_top_test;

  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic endPulse = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inValid = 1'b0;
  logic initN = 1'b1;
  logic doneIn = 1'b0;
  logic inReady, programN, chipSelN, writeN, cfgClk, busy, finished;
  logic [DATA_W-1:0] cfgData;

  int checks = 0;
  int fails = 0;
  logic [DATA_W-1:0] expBytes [0:511];
  int wrIdx = 0;
  int rdIdx = 0;

  always #4 clk = ~clk;

  cfg_seq_top #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .endPulse(endPulse),
    .inData(inData), .inValid(inValid), .inReady(inReady), .initN(initN),
    .doneIn(doneIn), .programN(programN), .chipSelN(chipSelN), .writeN(writeN),
    .cfgClk(cfgClk), .cfgData(cfgData), .busy(busy), .finished(finished)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pin monitor, sampled mid-cycle
  logic prevClk = 1'b0;
  logic [DATA_W-1:0] prevData = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (cfgClk && !prevClk) begin
        chk(cfgData == prevData, "R5 setup", cfgData, prevData);
        chk(!chipSelN && !writeN, "R7 select in pulse", {chipSelN, writeN}, 0);
        if (rdIdx < wrIdx) begin
          chk(cfgData == expBytes[rdIdx], "R6 byte order", cfgData, expBytes[rdIdx]);
          rdIdx++;
        end else begin
          chk(1'b0, "R6 extra pulse", rdIdx, wrIdx);
        end
      end
      if (cfgClk && prevClk) chk(1'b0, "R5 pulse width", 2, 1);
      if (!cfgClk && prevClk) chk(cfgData == prevData, "R5 hold", cfgData, prevData);
    end
    prevClk = cfgClk;
    prevData = cfgData;
  end

  task automatic bringUp();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    @(negedge clk);
    chk(!programN, "R2 program low", programN, 0);
    chk(busy, "R2 busy", busy, 1);
    repeat (3) @(negedge clk);
    chk(!programN, "R2 program held", programN, 0);
    chk(chipSelN && !inReady, "R2 no load in clear", {chipSelN, inReady}, 2);
    initN = 1'b0;
    repeat (2) @(negedge clk);
    chk(programN, "R3 program released", programN, 1);
    repeat (3) @(negedge clk);
    chk(chipSelN && writeN && !inReady, "R3 waits for init high",
        {chipSelN, writeN, inReady}, 6);
    initN = 1'b1;
    @(negedge clk);
    chk(inReady, "R4 ready", inReady, 1);
    @(negedge clk);
    chk(!chipSelN && !writeN, "R4 select and write low", {chipSelN, writeN}, 0);
    wrIdx = 0;
    rdIdx = 0;
  endtask

  task automatic sendByte(input logic [DATA_W-1:0] b, input int gap);
    repeat (gap) @(negedge clk);
    inValid = 1'b1;
    inData = b;
    while (!inReady) @(negedge clk);
    expBytes[wrIdx] = b;
    wrIdx++;
    @(negedge clk);
    inValid = 1'b0;
    chk(!inReady, "R6 ready drops", inReady, 0);
    chk(!chipSelN && !writeN, "R7 held between bytes", {chipSelN, writeN}, 0);
  endtask

  task automatic checkFinished(input string req);
    chk(chipSelN && writeN, {req, " released"}, {chipSelN, writeN}, 3);
    chk(finished && !busy, {req, " finished"}, {finished, busy}, 2);
    chk(!inReady, {req, " ready low"}, inReady, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(programN && chipSelN && writeN && !cfgClk, "R1 pins",
        {programN, chipSelN, writeN, cfgClk}, 14);
    chk(!busy && !finished && !inReady, "R1 status", {busy, finished, inReady}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(programN && !busy, "R1 idle after reset", {programN, busy}, 2);

    // Pass 1: every byte value, back to back
    bringUp();
    for (int i = 0; i < 256; i++) sendByte(i[7:0], 0);
    repeat (4) @(negedge clk);
    chk(rdIdx == wrIdx, "R6 pulse count", rdIdx, wrIdx);
    doneIn = 1'b1;
    repeat (2) @(negedge clk);
    doneIn = 1'b0;
    checkFinished("R8");

    // Pass 2: computed bytes with idle gaps, ended by endPulse
    bringUp();
    for (int i = 0; i < 64; i++) sendByte(8'((i * 73 + 5) & 255), i % 4);
    repeat (4) @(negedge clk);
    chk(rdIdx == wrIdx, "R6 pulse count with gaps", rdIdx, wrIdx);
    endPulse = 1'b1;
    @(negedge clk) endPulse = 1'b0;
    @(negedge clk);
    checkFinished("R9");

    // Pass 3: restart in the middle of a load
    bringUp();
    for (int i = 0; i < 5; i++) sendByte(8'(200 + i), 1);
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    @(negedge clk);
    chk(!programN && chipSelN, "R10 back to clear", {programN, chipSelN}, 1);
    chk(busy && !inReady, "R10 busy not ready", {busy, inReady}, 2);
    initN = 1'b0;
    repeat (2) @(negedge clk);
    initN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!chipSelN && inReady, "R4 load after restart", {chipSelN, inReady}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule